// File: doc/BRIEF.md
# Hourly Chime and Clip Playback Sequencer

This block is the control core of a desk clock that has a thermometer, a buzzer and a serial link to a host computer. It watches the BCD minutes from a free-running clock and detects the roll-over to minute 00. At that moment it starts the built-in alarm melody for a bounded time and sends the present temperature reading to the host as a short ASCII line, one byte per transmitter handshake.

The host can answer with a short audio clip, one note code per received byte. The sequencer writes these notes into an external note buffer. When the clip is complete it asks the tone generator to play it and freezes the time and temperature it hands to the display. The real clock keeps counting during this time. When the tone generator reports that playback has ended, the display returns to live values. The serial bit timing, the tone PWM, the sensor interface and the display driver all sit outside this block.

Top module: `chime_seq`

## Requirements
- R1: `hour_pulse_o` is high for exactly one cycle, one clock after a cycle in which the sequencer is idle, `min_bcd_i` equals 8'h00 and the minute value seen on the previous clock was non-zero. The register holding the previous minute value resets to 8'h00.
- R2: The same event raises `alarm_on_o` in the same cycle as the pulse. It stays high for exactly ALARM_SECS × CLKS_PER_SEC cycles. A repeat event while the alarm sounds restarts that window.
- R3: The same event starts a six-byte report built from `temp_bcd_i` as sampled at the event, where bits [11:8] are tens, [7:4] are ones and [3:0] are tenths. The bytes are 8'h30+tens, 8'h30+ones, 8'h2E, 8'h30+tenths, 8'h0D and 8'h0A. `tx_valid_o` holds each byte until a cycle with `tx_ready_i` high. An event that arrives while a report is still pending starts no new report.
- R4: When idle, a received byte with a non-zero value starts reception. It is written to buffer address 0 through `note_we_o` one cycle later. A 8'h00 byte received while idle is ignored.
- R5: During reception, each non-zero byte is written at the next address. Reception ends on a 8'h00 byte, which is not stored, when MAX_NOTES notes have been stored, or after GAP_CYCLES consecutive cycles with no byte.
- R6: When reception ends, `clip_start_o` pulses for one cycle with `clip_len_o` equal to the number of stored notes, and `freeze_o` rises in that same cycle.
- R7: While `freeze_o` is high, `disp_time_o` ({hours, minutes}) and `disp_temp_o` hold the live input values from the cycle in which reception ended. At all other times they follow the live inputs with no delay.
- R8: `play_done_i` during playback clears `freeze_o` on the next clock and returns the block to idle. At any other time it has no effect.
- R9: A minute roll-over during reception or playback is ignored: no pulse, no alarm and no report. A received byte during playback is also ignored.
- R10: A non-zero byte received while the alarm sounds drops `alarm_on_o` on the next clock, and reception proceeds.
- R11: When a roll-over and a non-zero first byte arrive in the same cycle, the pulse and the report still happen, the alarm is not started, and reception begins.
- R12: Reset clears every output register and the alarm and report state, and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| hour_bcd_i | input | 8 | Live hours, two BCD digits |
| min_bcd_i | input | 8 | Live minutes, two BCD digits |
| temp_bcd_i | input | 12 | Live temperature: tens, ones, tenths in BCD |
| rx_valid_i | input | 1 | One-cycle strobe: a byte arrived from the host |
| rx_data_i | input | 8 | Received byte (note code, 8'h00 ends the clip) |
| tx_ready_i | input | 1 | Transmitter accepts a byte this cycle |
| play_done_i | input | 1 | Tone generator finished the received clip |
| hour_pulse_o | output | 1 | One-cycle top-of-hour pulse |
| alarm_on_o | output | 1 | Built-in alarm melody requested |
| tx_valid_o | output | 1 | Report byte offered to the transmitter |
| tx_data_o | output | 8 | Report byte |
| note_we_o | output | 1 | Note buffer write strobe |
| note_addr_o | output | $clog2(MAX_NOTES) | Note buffer write address |
| note_data_o | output | 8 | Note code to store |
| clip_start_o | output | 1 | One-cycle request to play the stored clip |
| clip_len_o | output | $clog2(MAX_NOTES+1) | Number of notes in the stored clip |
| freeze_o | output | 1 | Display held during clip playback |
| disp_time_o | output | 16 | Hours and minutes for the display |
| disp_temp_o | output | 12 | Temperature for the display |

## Verification
Two of the block's functions can land in the same cycle: the top-of-hour event and the first byte of a host clip. The bench forces this by changing the minute to 00 and presenting a non-zero byte on the same clock. It then checks at the ports that the pulse and the report go out, the alarm stays silent and the note is written at address 0. A second overlap is also exercised. A clip byte arrives while the alarm is still sounding, and the alarm must drop on the next clock while the byte starts reception. Throughout the run, a behavioural model built from queues and counters predicts every output on every clock.

// File: rtl/chime_pkg.sv
package chime_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_LOAD = 2'd1,
        SEQ_PLAY = 2'd2
    } seq_state_e;

    localparam logic [7:0] ASCII_ZERO = 8'h30;
    localparam logic [7:0] ASCII_DOT  = 8'h2E;
    localparam logic [7:0] ASCII_CR   = 8'h0D;
    localparam logic [7:0] ASCII_LF   = 8'h0A;
    localparam logic [7:0] NOTE_END   = 8'h00;
    localparam int         REPORT_LEN = 6;

endpackage

// File: rtl/chime_hour_detect.sv
module chime_hour_detect (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       enable_i,
    input  logic [7:0] min_i,
    output logic       fire_o,
    output logic       pulse_o
);

    typedef struct packed {
        logic [7:0] min;
        logic       pulse;
    } det_t;

    det_t det_d, det_q;

    assign fire_o = enable_i && (min_i == 8'h00) && (det_q.min != 8'h00);

    always_comb begin
        det_d       = det_q;
        det_d.min   = min_i;
        det_d.pulse = fire_o;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) det_q <= '0;
        else         det_q <= det_d;
    end

    assign pulse_o = det_q.pulse;

    // R1
    pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |=> !pulse_o);

    // R1
    pulse_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pulse_o |-> ($past(min_i) == 8'h00));

endmodule

// File: rtl/chime_alarm_timer.sv
module chime_alarm_timer #(
    parameter int CLKS_PER_SEC = 50_000_000,
    parameter int ALARM_SECS   = 30
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic cut_i,
    output logic active_o
);

    localparam int CYC_W = $clog2(CLKS_PER_SEC);
    localparam int SEC_W = $clog2(ALARM_SECS);

    typedef struct packed {
        logic             active;
        logic [CYC_W-1:0] cyc;
        logic [SEC_W-1:0] sec;
    } alm_t;

    alm_t alm_d, alm_q;

    always_comb begin
        alm_d = alm_q;
        if (start_i) begin
            alm_d.active = 1'b1;
            alm_d.cyc    = '0;
            alm_d.sec    = '0;
        end else if (cut_i) begin
            alm_d.active = 1'b0;
        end else if (alm_q.active) begin
            if (alm_q.cyc == CYC_W'(CLKS_PER_SEC - 1)) begin
                alm_d.cyc = '0;
                if (alm_q.sec == SEC_W'(ALARM_SECS - 1)) alm_d.active = 1'b0;
                else                                       alm_d.sec    = alm_q.sec + 1'b1;
            end else begin
                alm_d.cyc = alm_q.cyc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) alm_q <= '0;
        else         alm_q <= alm_d;
    end

    assign active_o = alm_q.active;

    // R2
    alarm_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(active_o) |-> $past(start_i));

    // R10
    alarm_cut_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cut_i && !start_i) |=> !active_o);

endmodule

// File: rtl/chime_temp_report.sv
module chime_temp_report
    import chime_pkg::*;
(
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        fire_i,
    input  logic [11:0] temp_i,
    input  logic        tx_ready_i,
    output logic        tx_valid_o,
    output logic [7:0]  tx_data_o
);

    localparam int IDX_W = $clog2(REPORT_LEN);

    typedef struct packed {
        logic             busy;
        logic [IDX_W-1:0] idx;
        logic [11:0]      digits;
    } rep_t;

    rep_t rep_d, rep_q;

    function automatic logic [7:0] frame_byte(input logic [IDX_W-1:0] idx,
                                              input logic [11:0]      dg);
        logic [7:0] b;
        case (idx)
            IDX_W'(0): b = ASCII_ZERO + {4'h0, dg[11:8]};
            IDX_W'(1): b = ASCII_ZERO + {4'h0, dg[7:4]};
            IDX_W'(2): b = ASCII_DOT;
            IDX_W'(3): b = ASCII_ZERO + {4'h0, dg[3:0]};
            IDX_W'(4): b = ASCII_CR;
            default:   b = ASCII_LF;
        endcase
        return b;
    endfunction

    always_comb begin
        rep_d = rep_q;
        if (!rep_q.busy && fire_i) begin
            rep_d.busy   = 1'b1;
            rep_d.idx    = '0;
            rep_d.digits = temp_i;
        end else if (rep_q.busy && tx_ready_i) begin
            if (rep_q.idx == IDX_W'(REPORT_LEN - 1)) begin
                rep_d.busy = 1'b0;
                rep_d.idx  = '0;
            end else begin
                rep_d.idx = rep_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) rep_q <= '0;
        else         rep_q <= rep_d;
    end

    assign tx_valid_o = rep_q.busy;
    assign tx_data_o  = frame_byte(rep_q.idx, rep_q.digits);

    // R3
    tx_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

    // R3
    frame_tail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tx_valid_o && tx_ready_i && tx_data_o == ASCII_LF) |=> !tx_valid_o);

endmodule

// File: rtl/chime_seq.sv
module chime_seq
    import chime_pkg::*;
#(
    parameter  int CLKS_PER_SEC = 50_000_000,
    parameter  int ALARM_SECS   = 30,
    parameter  int MAX_NOTES    = 40,
    parameter  int GAP_CYCLES   = 5_000_000,
    localparam int ADDR_W       = $clog2(MAX_NOTES),
    localparam int CNT_W        = $clog2(MAX_NOTES + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [7:0]        hour_bcd_i,
    input  logic [7:0]        min_bcd_i,
    input  logic [11:0]       temp_bcd_i,
    input  logic              rx_valid_i,
    input  logic [7:0]        rx_data_i,
    input  logic              tx_ready_i,
    input  logic              play_done_i,
    output logic              hour_pulse_o,
    output logic              alarm_on_o,
    output logic              tx_valid_o,
    output logic [7:0]        tx_data_o,
    output logic              note_we_o,
    output logic [ADDR_W-1:0] note_addr_o,
    output logic [7:0]        note_data_o,
    output logic              clip_start_o,
    output logic [CNT_W-1:0]  clip_len_o,
    output logic              freeze_o,
    output logic [15:0]       disp_time_o,
    output logic [11:0]       disp_temp_o
);

    localparam int GAP_W = $clog2(GAP_CYCLES);

    typedef struct packed {
        seq_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [GAP_W-1:0]  gap;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        wdata;
        logic              start;
        logic [CNT_W-1:0]  len;
        logic              freeze;
        logic [15:0]       hold_time;
        logic [11:0]       hold_temp;
    } seq_t;

    seq_t seq_d, seq_q;

    logic is_idle;
    logic rx_open;
    logic hour_fire;
    logic done_rx;

    assign is_idle = (seq_q.state == SEQ_IDLE);
    assign rx_open = is_idle && rx_valid_i && (rx_data_i != NOTE_END);

    chime_hour_detect i_detect (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (is_idle),
        .min_i    (min_bcd_i),
        .fire_o   (hour_fire),
        .pulse_o  (hour_pulse_o)
    );

    chime_alarm_timer #(
        .CLKS_PER_SEC (CLKS_PER_SEC),
        .ALARM_SECS   (ALARM_SECS)
    ) i_alarm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (hour_fire && !rx_open),
        .cut_i    (rx_open),
        .active_o (alarm_on_o)
    );

    chime_temp_report i_report (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .fire_i     (hour_fire),
        .temp_i     (temp_bcd_i),
        .tx_ready_i (tx_ready_i),
        .tx_valid_o (tx_valid_o),
        .tx_data_o  (tx_data_o)
    );

    always_comb begin
        seq_d       = seq_q;
        seq_d.we    = 1'b0;
        seq_d.start = 1'b0;
        done_rx     = 1'b0;
        case (seq_q.state)
            SEQ_IDLE: begin
                if (rx_open) begin
                    seq_d.we    = 1'b1;
                    seq_d.addr  = '0;
                    seq_d.wdata = rx_data_i;
                    seq_d.cnt   = CNT_W'(1);
                    seq_d.gap   = '0;
                    seq_d.state = SEQ_LOAD;
                end
            end
            SEQ_LOAD: begin
                if (rx_valid_i) begin
                    seq_d.gap = '0;
                    if (rx_data_i == NOTE_END) begin
                        done_rx = 1'b1;
                    end else begin
                        seq_d.we    = 1'b1;
                        seq_d.addr  = seq_q.cnt[ADDR_W-1:0];
                        seq_d.wdata = rx_data_i;
                        seq_d.cnt   = seq_q.cnt + 1'b1;
                        if (seq_q.cnt == CNT_W'(MAX_NOTES - 1)) done_rx = 1'b1;
                    end
                end else if (seq_q.gap == GAP_W'(GAP_CYCLES - 1)) begin
                    done_rx = 1'b1;
                end else begin
                    seq_d.gap = seq_q.gap + 1'b1;
                end
                if (done_rx) begin
                    seq_d.state     = SEQ_PLAY;
                    seq_d.start     = 1'b1;
                    seq_d.len       = seq_d.cnt;
                    seq_d.freeze    = 1'b1;
                    seq_d.hold_time = {hour_bcd_i, min_bcd_i};
                    seq_d.hold_temp = temp_bcd_i;
                end
            end
            SEQ_PLAY: begin
                if (play_done_i) begin
                    seq_d.state  = SEQ_IDLE;
                    seq_d.freeze = 1'b0;
                end
            end
            default: seq_d.state = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    assign note_we_o    = seq_q.we;
    assign note_addr_o  = seq_q.addr;
    assign note_data_o  = seq_q.wdata;
    assign clip_start_o = seq_q.start;
    assign clip_len_o   = seq_q.len;
    assign freeze_o     = seq_q.freeze;
    assign disp_time_o  = seq_q.freeze ? seq_q.hold_time : {hour_bcd_i, min_bcd_i};
    assign disp_temp_o  = seq_q.freeze ? seq_q.hold_temp : temp_bcd_i;

    // R5
    clip_len_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clip_start_o |-> (clip_len_o != '0 && int'(clip_len_o) <= MAX_NOTES));

    // R6
    freeze_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(freeze_o) |-> clip_start_o);

    // R7
    frozen_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (freeze_o && $past(freeze_o)) |-> ($stable(disp_time_o) && $stable(disp_temp_o)));

    // R8
    release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (freeze_o && play_done_i) |=> !freeze_o);

    // R9
    no_pulse_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        freeze_o |-> !hour_pulse_o);

endmodule

// File: tb/test_chime_seq.sv
module test_chime_seq;

    localparam int CPS  = 4;
    localparam int ASEC = 3;
    localparam int MAXN = 6;
    localparam int GAP  = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [7:0]  hour, min;
    logic [11:0] temp;
    logic        rx_valid;
    logic [7:0]  rx_data;
    logic        tx_ready = 1'b0;
    logic        play_done;
    logic        hour_pulse, alarm_on, tx_valid, note_we, clip_start, freeze;
    logic [7:0]  tx_data, note_data;
    logic [2:0]  note_addr, clip_len;
    logic [15:0] disp_time;
    logic [11:0] disp_temp;

    chime_seq #(
        .CLKS_PER_SEC (CPS),
        .ALARM_SECS   (ASEC),
        .MAX_NOTES    (MAXN),
        .GAP_CYCLES   (GAP)
    ) i_chime_seq (
        .clk_i (clk), .rst_ni (rst_n),
        .hour_bcd_i (hour), .min_bcd_i (min), .temp_bcd_i (temp),
        .rx_valid_i (rx_valid), .rx_data_i (rx_data),
        .tx_ready_i (tx_ready), .play_done_i (play_done),
        .hour_pulse_o (hour_pulse), .alarm_on_o (alarm_on),
        .tx_valid_o (tx_valid), .tx_data_o (tx_data),
        .note_we_o (note_we), .note_addr_o (note_addr), .note_data_o (note_data),
        .clip_start_o (clip_start), .clip_len_o (clip_len),
        .freeze_o (freeze), .disp_time_o (disp_time), .disp_temp_o (disp_temp)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;
    bit stall    = 1'b0;
    int cyc      = 0;

    // Reference model state
    int         m_state = 0;
    logic [7:0] m_prev  = 8'h00;
    int         m_alarm = 0;
    logic [7:0] m_txq[$];
    int         m_cnt = 0, m_gap = 0, m_len = 0;
    logic       m_pulse = 0, m_we = 0, m_start = 0, m_freeze = 0;
    logic [7:0] m_addr = 0, m_wdata = 0;
    logic [15:0] m_htime = 0;
    logic [11:0] m_htemp = 0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: got %0h expected %0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        cyc++;
        tx_ready = !stall && (cyc % 3 != 1);
    end

    always @(posedge clk) begin : model
        logic ev, ropen, busy, fin;
        if (!rst_n) begin
            m_state = 0; m_prev = 8'h00; m_alarm = 0; m_txq.delete();
            m_cnt = 0; m_gap = 0; m_len = 0; m_pulse = 0; m_we = 0;
            m_start = 0; m_freeze = 0; m_addr = 0; m_wdata = 0;
            m_htime = 0; m_htemp = 0;
        end else begin
            ev     = (m_state == 0) && (min == 8'h00) && (m_prev != 8'h00);
            ropen  = (m_state == 0) && rx_valid && (rx_data != 8'h00);
            m_prev = min;
            m_pulse = ev;
            if (ev && !ropen)   m_alarm = ASEC * CPS;
            else if (ropen)     m_alarm = 0;
            else if (m_alarm > 0) m_alarm--;
            busy = (m_txq.size() > 0);
            if (busy && tx_ready) void'(m_txq.pop_front());
            if (ev && !busy) begin
                m_txq.push_back(8'h30 + {4'h0, temp[11:8]});
                m_txq.push_back(8'h30 + {4'h0, temp[7:4]});
                m_txq.push_back(8'h2E);
                m_txq.push_back(8'h30 + {4'h0, temp[3:0]});
                m_txq.push_back(8'h0D);
                m_txq.push_back(8'h0A);
            end
            m_we = 0; m_start = 0; fin = 0;
            case (m_state)
                0: if (ropen) begin
                    m_we = 1; m_addr = 0; m_wdata = rx_data;
                    m_cnt = 1; m_gap = 0; m_state = 1;
                end
                1: begin
                    if (rx_valid) begin
                        m_gap = 0;
                        if (rx_data == 8'h00) fin = 1;
                        else begin
                            m_we = 1; m_addr = 8'(m_cnt); m_wdata = rx_data;
                            m_cnt++;
                            if (m_cnt == MAXN) fin = 1;
                        end
                    end else if (m_gap == GAP - 1) fin = 1;
                    else m_gap++;
                    if (fin) begin
                        m_state = 2; m_start = 1; m_len = m_cnt; m_freeze = 1;
                        m_htime = {hour, min}; m_htemp = temp;
                    end
                end
                default: if (play_done) begin
                    m_state = 0; m_freeze = 0;
                end
            endcase
        end
    end

    always @(posedge clk) begin
        #5;
        if (!rst_n) begin
            chk("R12", "hour_pulse", 32'(hour_pulse), 0);
            chk("R12", "alarm_on",   32'(alarm_on), 0);
            chk("R12", "tx_valid",   32'(tx_valid), 0);
            chk("R12", "note_we",    32'(note_we), 0);
            chk("R12", "freeze",     32'(freeze), 0);
        end else begin
            chk("R1", "hour_pulse", 32'(hour_pulse), 32'(m_pulse));
            chk("R2", "alarm_on",   32'(alarm_on), 32'(m_alarm > 0));
            chk("R3", "tx_valid",   32'(tx_valid), 32'(m_txq.size() > 0));
            if (m_txq.size() > 0) chk("R3", "tx_data", 32'(tx_data), 32'(m_txq[0]));
            chk("R4", "note_we",    32'(note_we), 32'(m_we));
            if (m_we) begin
                chk("R5", "note_addr", 32'(note_addr), 32'(m_addr));
                chk("R5", "note_data", 32'(note_data), 32'(m_wdata));
            end
            chk("R6", "clip_start", 32'(clip_start), 32'(m_start));
            chk("R6", "clip_len",   32'(clip_len), 32'(m_len));
            chk("R8", "freeze",     32'(freeze), 32'(m_freeze));
            chk("R7", "disp_time",  32'(disp_time), 32'(m_freeze ? m_htime : {hour, min}));
            chk("R7", "disp_temp",  32'(disp_temp), 32'(m_freeze ? m_htemp : temp));
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_data = 8'h00;
    endtask

    task automatic pulse_done;
        @(negedge clk); play_done = 1'b1;
        @(negedge clk); play_done = 1'b0;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_err++;
        $display("FAIL R12 watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 1'b0; hour = 8'h07; min = 8'h58; temp = 12'h235;
        rx_valid = 1'b0; rx_data = 8'h00; play_done = 1'b0;
        wait_cyc(3);
        rst_n = 1'b1;

        // First hour: alarm runs to its limit, report sent with ready gaps
        wait_cyc(3); min = 8'h59;
        wait_cyc(3); hour = 8'h08; min = 8'h00;
        wait_cyc(22);

        // Report stalled; second event restarts alarm but not the report
        stall = 1'b1; min = 8'h01;
        wait_cyc(2); temp = 12'h187; min = 8'h00;
        wait_cyc(3); min = 8'h02;
        wait_cyc(2); min = 8'h00;
        wait_cyc(3); stall = 1'b0;
        wait_cyc(20);

        // Byte during alarm cuts it; clip ends with the end code
        min = 8'h01;
        wait_cyc(2); min = 8'h00;
        wait_cyc(3);
        send_byte(8'h0C);
        chk("R10", "alarm_on after byte", 32'(alarm_on), 0);
        wait_cyc(1); send_byte(8'h0D);
        wait_cyc(2); send_byte(8'h11);
        send_byte(8'h00);
        wait_cyc(2); min = 8'h05; temp = 12'h240; hour = 8'h09;
        wait_cyc(1); min = 8'h00;
        @(negedge clk);
        chk("R9", "hour_pulse in playback", 32'(hour_pulse), 0);
        chk("R9", "tx_valid in playback",   32'(tx_valid), 0);
        send_byte(8'h44);
        chk("R9", "note_we in playback", 32'(note_we), 0);
        wait_cyc(3);
        pulse_done();
        chk("R8", "freeze after done", 32'(freeze), 0);
        wait_cyc(3);

        // Clip ends by reaching the note limit; surplus byte ignored
        min = 8'h10;
        for (int k = 1; k <= MAXN + 1; k++) send_byte(8'(k + 8'h20));
        wait_cyc(4);
        pulse_done();
        wait_cyc(2);

        // Clip ends by gap timeout
        send_byte(8'h31); send_byte(8'h32);
        wait_cyc(GAP + 4);
        pulse_done();

        // Zero byte while idle, completion strobe while idle
        send_byte(8'h00);
        chk("R4", "note_we after idle zero byte", 32'(note_we), 0);
        pulse_done();
        chk("R8", "freeze after idle done", 32'(freeze), 0);
        wait_cyc(2);

        // Roll-over and first byte in the same cycle
        min = 8'h33;
        wait_cyc(2);
        min = 8'h00; rx_valid = 1'b1; rx_data = 8'h21;
        @(negedge clk);
        rx_valid = 1'b0; rx_data = 8'h00;
        chk("R11", "hour_pulse", 32'(hour_pulse), 1);
        chk("R11", "alarm_on",   32'(alarm_on), 0);
        chk("R11", "tx_valid",   32'(tx_valid), 1);
        chk("R11", "note_we",    32'(note_we), 1);
        chk("R11", "note_addr",  32'(note_addr), 0);
        // Roll-over during reception is ignored
        min = 8'h34;
        @(negedge clk); min = 8'h00;
        @(negedge clk);
        chk("R9", "hour_pulse in reception", 32'(hour_pulse), 0);
        send_byte(8'h00);
        wait_cyc(3);
        pulse_done();
        wait_cyc(10);
        finish_run();
    end

endmodule